// File: doc/BRIEF.md
# Configuration Access Port Translator

This block sits on a host I/O bus and implements the indirect, two-port method of reaching device configuration registers. Software first writes a 32-bit selector into an address port. The selector names a bus, a device, a function and a dword register index, and carries an enable flag. Software then reads or writes a data port. While the enable flag is set, each data-port access is turned into one configuration request that carries the selected target, the host byte enables and the write data.

A target on the local segment (bus 0) gets a type-0 request. Its address phase drives a one-hot device select on the upper address lines. A target behind a bridge (any other bus) gets a type-1 request that carries the raw fields. The host is held off by a ready signal until the configuration side acknowledges. A target that does not answer yields all ones. Any access that is not a configuration access goes out unchanged on a plain I/O side port. This includes narrow accesses to the address port, data-port accesses while the enable flag is clear, and accesses to any other I/O address.

Top module: `pci_cfg_port`

## Requirements
- R1: A write to I/O address 0x0CF8 with all four byte enables set (io_be = 4'b1111) loads the selector. Bits 30:24 and bits 1:0 are stored as zero. A full-dword read of 0x0CF8 returns the stored selector. Both complete with io_ready one cycle after acceptance.
- R2: An access to 0x0CF8 with any byte enable clear is forwarded on the plain I/O side with its address, byte enables and data, and leaves the selector unchanged.
- R3: While selector bit 31 (enable) is 0, an access to the data port 0x0CFC is forwarded on the plain I/O side and raises no configuration request.
- R4: With the enable set and selector bits 23:16 (bus) equal to 0, a data-port access raises a type-0 request (cfg_type1 = 0). Its cfg_addr has exactly one of bits 31:11 set, at bit 11 + device (device = selector bits 15:11, valid for 0 to 20). Bits 10:8 carry the function (selector bits 10:8), bits 7:2 the register index (selector bits 7:2), and bits 1:0 are 00.
- R5: With the enable set and a non-zero bus, the request is type-1 (cfg_type1 = 1) with cfg_addr = {8'h00, bus, device, function, register, 2'b01}.
- R6: The request carries the data-port access direction on cfg_we, its byte enables on cfg_be and its write data on cfg_wdata.
- R7: cfg_req stays high and io_ready stays low until cfg_ack. On the acknowledging edge the read data cfg_rdata is captured and returned on io_rdata with io_ready in the next cycle.
- R8: An acknowledge with cfg_abort set returns 32'hFFFF_FFFF to the host.
- R9: With the enable set, bus 0 and a device number above 20, no request is raised. A read returns 32'hFFFF_FFFF, and a write completes without effect.
- R10: An access to any other I/O address is forwarded on the plain I/O side (pio_req held until pio_ack), and pio_rdata is returned to the host.
- R11: After reset the selector reads as zero, io_ready is low and neither cfg_req nor pio_req is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| io_req | input | 1 | Host access request, held until io_ready |
| io_we | input | 1 | Host access is a write |
| io_addr | input | IO_AW | Host I/O address |
| io_be | input | 4 | Host byte enables |
| io_wdata | input | 32 | Host write data |
| io_rdata | output | 32 | Read data returned to host |
| io_ready | output | 1 | One-cycle completion strobe |
| cfg_req | output | 1 | Configuration request, held until cfg_ack |
| cfg_we | output | 1 | Configuration write |
| cfg_type1 | output | 1 | Request targets a bus behind a bridge |
| cfg_bus | output | 8 | Selected bus number |
| cfg_dev | output | 5 | Selected device number |
| cfg_fn | output | 3 | Selected function number |
| cfg_reg | output | 6 | Selected dword register index |
| cfg_addr | output | 32 | Address phase value (device select or type-1 form) |
| cfg_be | output | 4 | Byte enables of the configuration access |
| cfg_wdata | output | 32 | Configuration write data |
| cfg_rdata | input | 32 | Configuration read data |
| cfg_ack | input | 1 | Configuration completion |
| cfg_abort | input | 1 | No target answered |
| pio_req | output | 1 | Plain I/O request, held until pio_ack |
| pio_we | output | 1 | Plain I/O write |
| pio_addr | output | IO_AW | Plain I/O address |
| pio_be | output | 4 | Plain I/O byte enables |
| pio_wdata | output | 32 | Plain I/O write data |
| pio_rdata | input | 32 | Plain I/O read data |
| pio_ack | input | 1 | Plain I/O completion |

## Verification
A corrupted selector shows up at the very next data-port access. The wrong select bit or field appears on cfg_addr in the first cycle of cfg_req, and a full read of the address port shows it one cycle after acceptance. A wrong routing decision shows up as a request on the wrong side port, which the bench targets flag as unexpected in the cycle it appears. A wrong completion path shows up as a wrong io_rdata or a missing io_ready within a few cycles of the acknowledge.

// File: rtl/pci_cfg_port.sv
module pci_cfg_port #(
  parameter int IO_AW = 16,
  parameter logic [IO_AW-1:0] ADDR_PORT = 16'h0CF8,
  parameter logic [IO_AW-1:0] DATA_PORT = 16'h0CFC,
  parameter int SEL_LSB = 11,
  parameter int SEL_MSB = 31
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             io_req,
  input  logic             io_we,
  input  logic [IO_AW-1:0] io_addr,
  input  logic [3:0]       io_be,
  input  logic [31:0]      io_wdata,
  output logic [31:0]      io_rdata,
  output logic             io_ready,
  output logic             cfg_req,
  output logic             cfg_we,
  output logic             cfg_type1,
  output logic [7:0]       cfg_bus,
  output logic [4:0]       cfg_dev,
  output logic [2:0]       cfg_fn,
  output logic [5:0]       cfg_reg,
  output logic [31:0]      cfg_addr,
  output logic [3:0]       cfg_be,
  output logic [31:0]      cfg_wdata,
  input  logic [31:0]      cfg_rdata,
  input  logic             cfg_ack,
  input  logic             cfg_abort,
  output logic             pio_req,
  output logic             pio_we,
  output logic [IO_AW-1:0] pio_addr,
  output logic [3:0]       pio_be,
  output logic [31:0]      pio_wdata,
  input  logic [31:0]      pio_rdata,
  input  logic             pio_ack
);

  localparam int NUM_SEL = SEL_MSB - SEL_LSB + 1;
  localparam logic [4:0] MAX_DEV = 5'(NUM_SEL - 1);
  localparam logic [31:0] KEEP_MASK = 32'h80FF_FFFC;

  typedef enum logic [1:0] {S_IDLE, S_CFG, S_PIO, S_DONE} state_t;

  state_t            state;
  logic [31:0]       sel_q;
  logic [31:0]       rdata_q;
  logic              h_we;
  logic [IO_AW-1:0]  h_addr;
  logic [3:0]        h_be;
  logic [31:0]       h_wdata;

  wire        en      = sel_q[31];
  wire        is_t1   = sel_q[23:16] != 8'd0;
  wire        dev_ok  = sel_q[15:11] <= MAX_DEV;
  wire        hit_a   = io_addr == ADDR_PORT;
  wire        hit_d   = io_addr == DATA_PORT;
  wire        full    = &io_be;
  wire        take_sel = hit_a && full;
  wire        take_cfg = hit_d && en;

  logic [31:0] dev_sel;
  always_comb begin
    dev_sel = '0;
    if (dev_ok) dev_sel = 32'd1 << (SEL_LSB + 32'(sel_q[15:11]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      sel_q   <= '0;
      rdata_q <= '0;
      h_we    <= 1'b0;
      h_addr  <= '0;
      h_be    <= '0;
      h_wdata <= '0;
    end else begin
      case (state)
        S_IDLE: if (io_req) begin
          h_we    <= io_we;
          h_addr  <= io_addr;
          h_be    <= io_be;
          h_wdata <= io_wdata;
          if (take_sel) begin
            if (io_we) sel_q <= io_wdata & KEEP_MASK;
            else       rdata_q <= sel_q;
            state <= S_DONE;
          end else if (take_cfg) begin
            if (!is_t1 && !dev_ok) begin
              rdata_q <= '1;
              state   <= S_DONE;
            end else begin
              state <= S_CFG;
            end
          end else begin
            state <= S_PIO;
          end
        end
        S_CFG: if (cfg_ack) begin
          rdata_q <= cfg_abort ? '1 : cfg_rdata;
          state   <= S_DONE;
        end
        S_PIO: if (pio_ack) begin
          rdata_q <= pio_rdata;
          state   <= S_DONE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign io_ready  = state == S_DONE;
  assign io_rdata  = rdata_q;

  assign cfg_req   = state == S_CFG;
  assign cfg_we    = h_we;
  assign cfg_be    = h_be;
  assign cfg_wdata = h_wdata;
  assign cfg_type1 = is_t1;
  assign cfg_bus   = sel_q[23:16];
  assign cfg_dev   = sel_q[15:11];
  assign cfg_fn    = sel_q[10:8];
  assign cfg_reg   = sel_q[7:2];
  assign cfg_addr  = is_t1 ? {8'h00, sel_q[23:2], 2'b01}
                           : (dev_sel | {21'd0, sel_q[10:2], 2'b00});

  assign pio_req   = state == S_PIO;
  assign pio_we    = h_we;
  assign pio_addr  = h_addr;
  assign pio_be    = h_be;
  assign pio_wdata = h_wdata;

  AST_SEL_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    state != S_IDLE |=> $stable(sel_q)); // R1
  AST_NARROW_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && io_req && hit_a && !full) |=> (pio_req && $stable(sel_q))); // R2
  AST_DISABLED_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && io_req && hit_d && !en) |=> (pio_req && !cfg_req)); // R3
  AST_T0_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_req && !cfg_type1) |-> ($onehot(cfg_addr[31:11]) && cfg_addr[1:0] == 2'b00)); // R4
  AST_T1_FORM: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_req && cfg_type1) |-> (cfg_addr[1:0] == 2'b01 && cfg_bus != 8'd0)); // R5
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_req && !cfg_ack) |=> (cfg_req && !io_ready)); // R7
  AST_ABORT_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_req && cfg_ack && cfg_abort) |=> (io_ready && io_rdata == 32'hFFFF_FFFF)); // R8
  AST_NO_HIGH_DEV: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_req && !cfg_type1) |-> cfg_dev <= MAX_DEV); // R9
  AST_ONE_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_req && pio_req)); // R10
  AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    io_ready |=> !io_ready); // R7

endmodule

// File: tb/pci_cfg_port_test.sv
module pci_cfg_port_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic io_req = 0, io_we = 0;
  logic [15:0] io_addr = '0;
  logic [3:0] io_be = '0;
  logic [31:0] io_wdata = '0, io_rdata;
  logic io_ready;
  logic cfg_req, cfg_we, cfg_type1;
  logic [7:0] cfg_bus; logic [4:0] cfg_dev; logic [2:0] cfg_fn; logic [5:0] cfg_reg;
  logic [31:0] cfg_addr, cfg_wdata;
  logic [3:0] cfg_be;
  logic [31:0] cfg_rdata = '0;
  logic cfg_ack = 0, cfg_abort = 0;
  logic pio_req, pio_we;
  logic [15:0] pio_addr; logic [3:0] pio_be; logic [31:0] pio_wdata;
  logic [31:0] pio_rdata = '0;
  logic pio_ack = 0;

  pci_cfg_port uut (.*);

  int n_chk = 0, n_bad = 0;

  typedef struct { bit chk; logic [31:0] val; string tag; } rd_t;
  typedef struct { logic [31:0] addr; bit t1; bit we; logic [3:0] be; logic [31:0] wd;
                   logic [31:0] rd; bit ab; string tag; } cf_t;
  typedef struct { logic [15:0] addr; bit we; logic [3:0] be; logic [31:0] wd;
                   logic [31:0] rd; string tag; } pi_t;
  rd_t rdq[$];
  cf_t cfq[$];
  pi_t piq[$];

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_addr(logic [31:0] s);
    if (s[23:16] != 8'd0) return {8'h00, s[23:2], 2'b01};
    return (32'd1 << (11 + 32'(s[15:11]))) | {21'd0, s[10:2], 2'b00};
  endfunction

  task automatic host(bit we, logic [15:0] a, logic [3:0] be, logic [31:0] wd,
                      bit chk, logic [31:0] exp, string tag);
    rd_t r;
    r.chk = chk; r.val = exp; r.tag = tag;
    rdq.push_back(r);
    @(negedge clk);
    io_req = 1; io_we = we; io_addr = a; io_be = be; io_wdata = wd;
    do @(negedge clk); while (!io_ready);
    io_req = 0;
  endtask

  task automatic expect_cfg(logic [31:0] s, bit we, logic [3:0] be, logic [31:0] wd,
                            logic [31:0] rd, bit ab, string tag);
    cf_t c;
    c.addr = exp_addr(s); c.t1 = s[23:16] != 0; c.we = we; c.be = be; c.wd = wd;
    c.rd = rd; c.ab = ab; c.tag = tag;
    cfq.push_back(c);
  endtask

  task automatic expect_pio(logic [15:0] a, bit we, logic [3:0] be, logic [31:0] wd,
                            logic [31:0] rd, string tag);
    pi_t p;
    p.addr = a; p.we = we; p.be = be; p.wd = wd; p.rd = rd; p.tag = tag;
    piq.push_back(p);
  endtask

  // host completion monitor
  always @(negedge clk) if (rst_n && io_ready) begin
    rd_t r;
    if (rdq.size() == 0) check(0, "R7 completion with nothing pending", 32'd1, 32'd0);
    else begin
      r = rdq.pop_front();
      if (r.chk) check(io_rdata === r.val, r.tag, io_rdata, r.val);
    end
  end

  // configuration target
  initial forever begin
    @(negedge clk);
    if (rst_n && cfg_req) begin
      cf_t c;
      if (cfq.size() == 0) begin
        check(0, "R3 R9 unexpected cfg request", cfg_addr, 32'd0);
        c.rd = '0; c.ab = 1'b1;
      end else begin
        c = cfq.pop_front();
        check(cfg_addr === c.addr, {c.tag, " cfg_addr"}, cfg_addr, c.addr);
        check(cfg_type1 === c.t1, {c.tag, " cfg_type1"}, 32'(cfg_type1), 32'(c.t1));
        check(cfg_we === c.we && cfg_be === c.be, {c.tag, " R6 we/be"},
              {27'd0, cfg_we, cfg_be}, {27'd0, c.we, c.be});
        if (c.we) check(cfg_wdata === c.wd, {c.tag, " R6 wdata"}, cfg_wdata, c.wd);
      end
      @(negedge clk);
      check(cfg_req === 1'b1 && io_ready === 1'b0, "R7 request held before ack",
            {30'd0, cfg_req, io_ready}, 32'd2);
      cfg_ack = 1; cfg_rdata = c.rd; cfg_abort = c.ab;
      @(negedge clk);
      cfg_ack = 0; cfg_abort = 0;
    end
  end

  // plain I/O target
  initial forever begin
    @(negedge clk);
    if (rst_n && pio_req) begin
      pi_t p;
      if (piq.size() == 0) begin
        check(0, "R10 unexpected pio request", {16'd0, pio_addr}, 32'd0);
        p.rd = '0;
      end else begin
        p = piq.pop_front();
        check(pio_addr === p.addr && pio_we === p.we && pio_be === p.be,
              {p.tag, " pio addr/we/be"}, {11'd0, pio_we, pio_be, pio_addr},
              {11'd0, p.we, p.be, p.addr});
        if (p.we) check(pio_wdata === p.wd, {p.tag, " pio wdata"}, pio_wdata, p.wd);
      end
      pio_ack = 1; pio_rdata = p.rd;
      @(negedge clk);
      pio_ack = 0;
    end
  end

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual running expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(io_ready === 0 && cfg_req === 0 && pio_req === 0, "R11 reset outputs",
          {29'd0, io_ready, cfg_req, pio_req}, 32'd0);
    rst_n = 1;
    host(0, 16'h0CF8, 4'hF, 0, 1, 32'h0, "R11 selector after reset");

    // R1: load with reserved and low bits set; bus0 dev3 fn2 reg 0x10
    host(1, 16'h0CF8, 4'hF, 32'hFF00_1A41, 0, 0, "R1 write");
    host(0, 16'h0CF8, 4'hF, 0, 1, 32'h8000_1A40, "R1 readback masked");

    // R2: narrow accesses to address port
    expect_pio(16'h0CF8, 1, 4'b0011, 32'h0000_FFFF, 0, "R2 narrow write");
    host(1, 16'h0CF8, 4'b0011, 32'h0000_FFFF, 0, 0, "R2 narrow write");
    expect_pio(16'h0CF8, 0, 4'b0001, 0, 32'h0000_00AB, "R2 narrow read");
    host(0, 16'h0CF8, 4'b0001, 0, 1, 32'h0000_00AB, "R2 narrow read data");
    host(0, 16'h0CF8, 4'hF, 0, 1, 32'h8000_1A40, "R2 selector unchanged");

    // R4 R7: type-0 read
    expect_cfg(32'h8000_1A40, 0, 4'hF, 0, 32'h1234_5678, 0, "R4 type0 read");
    host(0, 16'h0CFC, 4'hF, 0, 1, 32'h1234_5678, "R7 cfg read data");
    // R6: partial write
    expect_cfg(32'h8000_1A40, 1, 4'b0110, 32'hCAFE_F00D, 0, 0, "R6 partial write");
    host(1, 16'h0CFC, 4'b0110, 32'hCAFE_F00D, 0, 0, "R6 write");
    // R8: abort
    expect_cfg(32'h8000_1A40, 0, 4'hF, 0, 32'h5555_5555, 1, "R8 abort");
    host(0, 16'h0CFC, 4'hF, 0, 1, 32'hFFFF_FFFF, "R8 abort read ones");

    // R4 boundary: device 20 selects bit 31
    host(1, 16'h0CF8, 4'hF, 32'h8000_A304, 0, 0, "R4 dev20 select");
    expect_cfg(32'h8000_A304, 0, 4'b1000, 0, 32'h0BAD_BEEF, 0, "R4 dev20");
    host(0, 16'h0CFC, 4'b1000, 0, 1, 32'h0BAD_BEEF, "R4 dev20 read");

    // R5: type-1, bus 5 dev 7 fn1 reg 3
    host(1, 16'h0CF8, 4'hF, 32'h8005_390C, 0, 0, "R5 select");
    expect_cfg(32'h8005_390C, 0, 4'hF, 0, 32'hA5A5_0001, 0, "R5 type1 read");
    host(0, 16'h0CFC, 4'hF, 0, 1, 32'hA5A5_0001, "R5 read data");
    expect_cfg(32'h8005_390C, 1, 4'b0001, 32'h0000_0077, 0, 0, "R5 type1 write");
    host(1, 16'h0CFC, 4'b0001, 32'h0000_0077, 0, 0, "R5 write");

    // R9: device 21 on bus 0, no request
    host(1, 16'h0CF8, 4'hF, 32'h8000_A800, 0, 0, "R9 select");
    host(0, 16'h0CFC, 4'hF, 0, 1, 32'hFFFF_FFFF, "R9 dev21 read ones");
    host(1, 16'h0CFC, 4'hF, 32'h1111_2222, 0, 0, "R9 dev21 write");
    host(0, 16'h0CF8, 4'hF, 0, 1, 32'h8000_A800, "R9 selector intact");

    // R3: enable off
    host(1, 16'h0CF8, 4'hF, 32'h0000_1A40, 0, 0, "R3 select off");
    expect_pio(16'h0CFC, 0, 4'hF, 0, 32'h3C3C_3C3C, "R3 data port as io");
    host(0, 16'h0CFC, 4'hF, 0, 1, 32'h3C3C_3C3C, "R3 disabled read forwarded");

    // R10: other ports
    expect_pio(16'h0080, 1, 4'b0001, 32'h0000_0042, 0, "R10 write");
    host(1, 16'h0080, 4'b0001, 32'h0000_0042, 0, 0, "R10 write");
    expect_pio(16'h0CFD, 0, 4'b0010, 0, 32'h0000_9900, "R10 read");
    host(0, 16'h0CFD, 4'b0010, 0, 1, 32'h0000_9900, "R10 read data");

    repeat (4) @(negedge clk);
    check(cfq.size() == 0, "R4 pending cfg expectations", 32'(cfq.size()), 32'd0);
    check(piq.size() == 0, "R10 pending pio expectations", 32'(piq.size()), 32'd0);
    check(rdq.size() == 0, "R7 pending completions", 32'(rdq.size()), 32'd0);
    finish_run();
  end
endmodule